// File: doc/BRIEF.md
# Word-Complete Interrupt Status and Enable Bank

This block holds the interrupt state of a serial flash controller. The
transfer engine raises a one-cycle `word_done` pulse whenever it finishes a
word. The pulse sets a pending status bit, and that bit stays set until
software clears it. A single enable bit gates the pending status onto a
level-sensitive `irq` output.

Software reaches the bank through a plain 32-bit register port that uses
byte addresses on word boundaries. Reads are combinational from `addr`, and
writes take effect on the clock edge on which `wr_en` is sampled. Status and
enable are each changed through separate set and clear addresses, and a
write changes only the bits written as 1. Software therefore never needs a
read-modify-write sequence, and a clear cannot race with a concurrent update
of another bit.

The status can be read in two ways: unmasked, or masked by the enable. This
lets a handler tell a disabled but pending event apart from one that is
raising the line.

Top module: `irq_stat_bank`

## Requirements
- R1: A `word_done` pulse sets the pending status bit (bit 1) on the next clock edge. The bit then stays set until it is cleared by a write.
- R2: A read at byte offset 0x20 (raw view) returns the pending status in bit 1. All other bits read 0.
- R3: A read at offset 0x24 (enabled view) returns the pending status AND the enable in bit 1. All other bits read 0.
- R4: A write at offset 0x24 with bit 1 set clears the pending status on the next edge.
- R5: A write at offset 0x20 with bit 1 set forces the pending status to 1 on the next edge.
- R6: A write at offset 0x28 with bit 1 set turns the enable on. A write at offset 0x2C with bit 1 set turns it off. A read at either offset returns the enable in bit 1, and all other bits read 0.
- R7: `irq` is high, as a level, in exactly the cycles in which both the pending status and the enable are 1.
- R8: When a `word_done` pulse and a clearing write at 0x24 fall in the same cycle, the pending status is 1 afterwards.
- R9: A write whose bit 1 is 0, or a write to any other offset, leaves both the status and the enable unchanged. Reads at other offsets return 0.
- R10: After reset, the status and the enable are both 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| word_done | input | 1 | One-cycle word-complete event |
| irq | output | 1 | Level interrupt request |

## Verification
Assertions are checked on every cycle. They cover the following edge-to-edge
rules:
- an event sets the status;
- a clearing write drops the status, except when an event arrives in the same cycle, in which case the event wins;
- the enable set and clear writes move the mask;
- with no write and no event, both bits hold.

Other behaviour can only be shown by the bench scenarios, where the reference
model compares every cycle. These scenarios cover:
- the contents of the raw and masked views;
- the fact that writes of zero or writes to unused offsets leave nothing behind;
- that `irq` follows the masked status as a level through each enable and clear order.

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int EVT_BIT = 1,
  parameter logic [ADDR_W-1:0] OFF_RAW = 'h20,
  parameter logic [ADDR_W-1:0] OFF_ENA = 'h24,
  parameter logic [ADDR_W-1:0] OFF_MSET = 'h28,
  parameter logic [ADDR_W-1:0] OFF_MCLR = 'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              word_done,
  output logic              irq
);

  localparam int WA = ADDR_W - 2;

  logic stat_q, en_q;
  logic [WA-1:0] waddr;
  logic hit_raw, hit_ena, hit_mset, hit_mclr, wbit;

  assign waddr    = addr[ADDR_W-1:2];
  assign hit_raw  = waddr == OFF_RAW[ADDR_W-1:2];
  assign hit_ena  = waddr == OFF_ENA[ADDR_W-1:2];
  assign hit_mset = waddr == OFF_MSET[ADDR_W-1:2];
  assign hit_mclr = waddr == OFF_MCLR[ADDR_W-1:2];
  assign wbit     = wdata[EVT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (word_done || (wr_en && hit_raw && wbit)) begin
      stat_q <= 1'b1;
    end else if (wr_en && hit_ena && wbit) begin
      stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (wr_en && hit_mset && wbit) begin
      en_q <= 1'b1;
    end else if (wr_en && hit_mclr && wbit) begin
      en_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_raw)                rdata[EVT_BIT] = stat_q;
    else if (hit_ena)           rdata[EVT_BIT] = stat_q & en_q;
    else if (hit_mset || hit_mclr) rdata[EVT_BIT] = en_q;
  end

  assign irq = stat_q & en_q;

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], wdata};

  assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> stat_q);

  assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ena && wbit && !word_done) |=> !stat_q);

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ena && wbit && word_done) |=> stat_q);

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_mset && wbit) |=> en_q);

  assert_mask_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_mclr && wbit) |=> !en_q);

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !word_done) |=> ($stable(stat_q) && $stable(en_q)));

endmodule

// File: tb/test_irq_stat_bank.sv
module test_irq_stat_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h20;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        word_done = 1'b0;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  string req = "R10";

  int m_stat = 0, m_en = 0;
  logic p_we = 0, p_evt = 0, p_rst = 0;
  logic [7:0] p_addr = 0;
  logic [31:0] p_wdata = 0;

  always #5 clk = ~clk;

  irq_stat_bank i_irq_stat_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .word_done(word_done), .irq(irq)
  );

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] v = '0;
    case (a)
      8'h20: v[1] = m_stat[0];
      8'h24: v[1] = m_stat[0] & m_en[0];
      8'h28, 8'h2C: v[1] = m_en[0];
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0;
    end else if (p_rst) begin
      if (p_evt) m_stat = 1;
      if (p_we && p_wdata[1]) begin
        if (p_addr == 8'h20) m_stat = 1;
        if (p_addr == 8'h24 && !p_evt) m_stat = 0;
        if (p_addr == 8'h28) m_en = 1;
        if (p_addr == 8'h2C) m_en = 0;
      end
    end
    compared++;
    if (rdata !== exp_rd(addr)) begin
      mismatched++;
      $display("FAIL %s rdata at %h: actual %h expected %h", req, addr, rdata, exp_rd(addr));
    end
    compared++;
    if (irq !== (m_stat[0] & m_en[0])) begin
      mismatched++;
      $display("FAIL %s/R7 irq: actual %b expected %b", req, irq, m_stat[0] & m_en[0]);
    end
    p_rst = rst_n; p_we = wr_en; p_evt = word_done; p_addr = addr; p_wdata = wdata;
  end

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d, input logic ev);
    @(posedge clk); #2;
    wr_en = we; addr = a; wdata = d; word_done = ev;
  endtask

  task automatic rd_all();
    cyc(0, 8'h20, 0, 0); cyc(0, 8'h24, 0, 0); cyc(0, 8'h28, 0, 0); cyc(0, 8'h2C, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    req = "R10";  rd_all();           // reset values observed before release
    @(posedge clk); #2; rst_n = 1'b1;
    rd_all();
    req = "R1";   cyc(0, 8'h20, 0, 1); rd_all();          // event sets raw, R2 view
    req = "R3";   cyc(0, 8'h24, 0, 0);                     // masked view still 0
    req = "R9";   cyc(1, 8'h28, 32'hFFFF_FFFD, 0); rd_all(); // zero in bit 1: no effect
    req = "R6";   cyc(1, 8'h28, 32'h2, 0); rd_all();       // enable on, irq R7
    req = "R9";   cyc(1, 8'h24, 32'h0, 0); cyc(1, 8'h30, 32'hFFFF_FFFF, 0);
    cyc(0, 8'h30, 0, 0); cyc(0, 8'h00, 0, 0); rd_all();
    req = "R4";   cyc(1, 8'h24, 32'h2, 0); rd_all();
    req = "R5";   cyc(1, 8'h20, 32'h2, 0); rd_all();
    req = "R8";   cyc(1, 8'h24, 32'h2, 1); rd_all();
    req = "R6";   cyc(1, 8'h2C, 32'h2, 0); rd_all();
    req = "R7";   cyc(1, 8'h28, 32'h2, 0); cyc(1, 8'h24, 32'h2, 0); rd_all();
    req = "R1";   cyc(0, 8'h24, 0, 1); cyc(0, 8'h24, 0, 0); cyc(0, 8'h24, 0, 0);
    req = "mixed";
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      a = 8'h20 + 8'(4 * $urandom_range(0, 4));
      cyc(1'($urandom_range(0, 1)), a, {30'($urandom), 1'($urandom), 1'($urandom)},
          ($urandom_range(0, 5) == 0));
    end
    cyc(0, 8'h20, 0, 0); cyc(0, 8'h20, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule